// File: doc/BRIEF.md
# Host-side ADC acquisition sequencer

This block is the master side of a four-wire serial link to a 16-bit successive-approximation converter with an eight-input multiplexer. It drives chip select, the serial clock and the serial command line from the system clock. It reads the converter's serial data and busy lines. After a start pulse it walks a programmed list of channel entries, and for each entry it sends one command byte. It then assembles the 16-bit straight-binary result, MSB first, and presents the result with the index of the list entry that produced it and a one-cycle valid strobe.

Three framings are available. The first is a compact 24-clock frame, in which the first clock of the next command also captures the previous result's LSB. The second is a 32-clock frame, whose trailing zero bits are dropped. The third is an internal-conversion-clock frame, in which the serial clock is parked low until the converter's busy line has dropped and risen again. The block remembers which conversion-clock mode the converter was last put in. When that mode is unknown (after reset) or about to change, it first runs one setup conversion that writes the mode code, and it discards that result. This ordering puts the mode write ahead of any command that selects power-down between conversions.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, cs_no is 1, dclk_o is 0, din_o is 0 and valid_o is 0.
- R2: Each high and low phase of dclk_o lasts div_i+1 system clocks. The first rising edge after cs_no falls comes no sooner than div_i+1 clocks later.
- R3: Each command byte is sent MSB first, one bit per dclk_o rising edge, as bit7=1 (start), bits 6..4 = entry bits 3..1 (channel address), bit3=0, bit2 = entry bit 0 (single-ended select), bits 1..0 = power code. din_o changes only while dclk_o is low.
- R4: With long_frame_i=1 in external-clock mode, each conversion takes 32 dclk_o cycles. Result bits 15..0 are sampled on rising edges 10..25 of the frame (counting from 1), and the remaining clocks are ignored.
- R5: With long_frame_i=0 in external-clock mode, each conversion takes 24 dclk_o cycles. The LSB is sampled on the first rising edge of the next transfer, which also carries that transfer's start bit. A run ends with one 8-clock transfer with din_o held low.
- R6: With int_clk_i=1, after the 8 command clocks dclk_o stays low, with cs_no low, until busy_i has been seen low and then high. Then 24 clocks follow, and result bits 15..0 are sampled on read-phase rising edges 2..17. long_frame_i has no effect in this mode.
- R7: The first run after reset, and any run whose int_clk_i differs from the previous run's, begins with one setup conversion on entry 0. That conversion uses power code 2'b10 (internal clock) or 2'b11 (external clock), and its result is never presented on valid_o.
- R8: Regular conversions use power code 2'b00 when auto_pd_i=1, and otherwise the mode code of R7.
- R9: A run converts entries 0..last_idx_i in order. Entry k is list_i[4k+3:4k], and each result carries tag_o=k.
- R10: Configuration is captured only by a start_i pulse while no run is active. start_i and configuration changes during a run have no effect on that run.
- R11: Each result is presented with a single-cycle valid_o pulse, once per regular conversion.
- R12: Between runs cs_no is 1 and dclk_o is 0, and cs_no falls once per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins a run when idle |
| div_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| long_frame_i | input | 1 | 1 = 32-clock frame, 0 = 24-clock frame |
| int_clk_i | input | 1 | 1 = converter uses its internal conversion clock |
| auto_pd_i | input | 1 | 1 = request power-down between conversions |
| last_idx_i | input | TAG_W | Index of the last list entry to convert |
| list_i | input | 4*N_ENT | Channel list, 4 bits per entry |
| cs_no | output | 1 | Chip select, active low |
| dclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial command data to the converter |
| dout_i | input | 1 | Serial result data from the converter |
| busy_i | input | 1 | Converter busy line |
| result_o | output | 16 | Last delivered result, straight binary |
| tag_o | output | TAG_W | List index of the delivered result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest state to reach is the 24-clock pipeline at the edges of a run. The discarded setup result must still be shifted out during the first regular command, and the last real LSB is only captured by the trailing transfer. A behavioural converter model in the bench decodes every command byte, applies the mode code it receives, and returns a word built from the received byte and a running conversion count. A dropped, shifted or misattributed bit therefore shows up as a wrong value or tag. Internal-clock runs hold busy low for many cycles, which shows whether the serial clock stays parked, and a run is disturbed mid-flight with a new start and a new configuration.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CTRL_BITS = 8;
  localparam int RES_BITS  = 16;
  localparam int ENT_BITS  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT_LO, ST_WAIT_HI} seq_st_e;
  typedef enum logic [1:0] {FK_SETUP, FK_CONV, FK_FLUSH} frame_kind_e;

  // start, address[2:0], spare, single-ended, power code[1:0]
  function automatic logic [CTRL_BITS-1:0] mk_ctrl(logic [ENT_BITS-1:0] ent, logic [1:0] pd);
    return {1'b1, ent[3:1], 1'b0, ent[0], pd};
  endfunction
endpackage

// File: rtl/adc_seq_divider.sv
module adc_seq_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i || cnt_q == div_i)    cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == div_i);

  assert_half_period_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/adc_seq_cmd.sv
module adc_seq_cmd
  import adc_seq_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int TAG_W = 3,
  parameter int IDX_W = 5
) (
  input  logic [N_ENT*ENT_BITS-1:0] list_i,
  input  logic [TAG_W-1:0]          ptr_i,
  input  frame_kind_e               kind_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      active_i,
  input  logic                      int_i,
  input  logic                      auto_pd_i,
  input  logic                      long_i,
  output logic                      din_o,
  output logic [IDX_W-1:0]          frame_last_o
);
  localparam logic [IDX_W-1:0] L_CTRL  = IDX_W'(CTRL_BITS);
  localparam logic [IDX_W-1:0] L_FLUSH = IDX_W'(CTRL_BITS-1);
  localparam logic [IDX_W-1:0] L_SHORT = IDX_W'(3*CTRL_BITS-1);
  localparam logic [IDX_W-1:0] L_LONG  = IDX_W'(4*CTRL_BITS-1);
  localparam logic [2:0]       L_MSB   = 3'(CTRL_BITS-1);

  logic [ENT_BITS-1:0]  ent;
  logic [1:0]           pd;
  logic [CTRL_BITS-1:0] ctrl;

  assign ent  = list_i[ptr_i*ENT_BITS +: ENT_BITS];
  assign pd   = (kind_i == FK_SETUP || !auto_pd_i) ? {1'b1, !int_i} : 2'b00;
  assign ctrl = mk_ctrl(ent, pd);

  always_comb begin
    din_o = 1'b0;
    if (active_i && kind_i != FK_FLUSH && idx_i < L_CTRL)
      din_o = ctrl[L_MSB - idx_i[2:0]];
  end

  always_comb begin
    if (kind_i == FK_FLUSH) frame_last_o = L_FLUSH;
    else if (long_i)        frame_last_o = L_LONG;
    else                    frame_last_o = L_SHORT;
  end
endmodule

// File: rtl/adc_seq_rx.sv
module adc_seq_rx #(
  parameter int RES_W = 16,
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             deliver_i,
  input  logic             keep_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [RES_W-1:0] result_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o
);
  logic [RES_W-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      result_o <= '0;
      tag_o    <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (shift_i) sr_q <= {sr_q[RES_W-3:0], bit_i};
      if (deliver_i) begin
        result_o <= {sr_q, bit_i};
        tag_o    <= tag_i;
        valid_o  <= keep_i;
      end
    end
  end

  assert_valid_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int  DIV_W  = 8,
  parameter int  N_ENT  = 8,
  localparam int TAG_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int LIST_W = N_ENT * ENT_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                long_frame_i,
  input  logic                int_clk_i,
  input  logic                auto_pd_i,
  input  logic [TAG_W-1:0]    last_idx_i,
  input  logic [LIST_W-1:0]   list_i,
  output logic                cs_no,
  output logic                dclk_o,
  output logic                din_o,
  input  logic                dout_i,
  input  logic                busy_i,
  output logic [RES_BITS-1:0] result_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic                valid_o
);
  localparam int IDX_W = $clog2(4*CTRL_BITS);
  localparam logic [IDX_W-1:0] L_CTRL_LAST = IDX_W'(CTRL_BITS-1);
  localparam logic [IDX_W-1:0] L_SAMP_LO   = IDX_W'(CTRL_BITS+1);
  localparam logic [IDX_W-1:0] L_SAMP_HI_L = IDX_W'(CTRL_BITS+RES_BITS);
  localparam logic [IDX_W-1:0] L_SAMP_HI_S = IDX_W'(CTRL_BITS+RES_BITS-1);

  seq_st_e          st_q;
  frame_kind_e      kind_q;
  logic [TAG_W-1:0] ptr_q, last_q, pend_tag_q;
  logic [IDX_W-1:0] idx_q, frame_last;
  logic             hi_q, cs_n_q, pend_q, pend_keep_q;
  logic [DIV_W-1:0] div_q;
  logic             long_q, int_q, auto_q;
  logic [LIST_W-1:0] list_q;
  logic             mode_ok_q, mode_int_q;
  logic             busy_meta_q, busy_s_q;
  logic             tick, rise, in_win, shift, deliver, keep;
  logic [TAG_W-1:0] rx_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_meta_q <= 1'b1;
      busy_s_q    <= 1'b1;
    end else begin
      busy_meta_q <= busy_i;
      busy_s_q    <= busy_meta_q;
    end
  end

  adc_seq_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q != ST_RUN),
    .div_i  (div_q),
    .tick_o (tick)
  );

  adc_seq_cmd #(.N_ENT(N_ENT), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cmd (
    .list_i       (list_q),
    .ptr_i        (ptr_q),
    .kind_i       (kind_q),
    .idx_i        (idx_q),
    .active_i     (st_q != ST_IDLE),
    .int_i        (int_q),
    .auto_pd_i    (auto_q),
    .long_i       (long_q),
    .din_o        (din_o),
    .frame_last_o (frame_last)
  );

  // sampling on rising serial-clock edges
  assign rise    = (st_q == ST_RUN) && tick && !hi_q;
  assign in_win  = kind_q != FK_FLUSH && idx_q >= L_SAMP_LO &&
                   idx_q <= (long_q ? L_SAMP_HI_L : L_SAMP_HI_S);
  assign shift   = rise && (in_win || (idx_q == '0 && pend_q));
  assign deliver = rise && ((long_q && kind_q != FK_FLUSH && idx_q == L_SAMP_HI_L) ||
                            (idx_q == '0 && pend_q));
  assign keep    = pend_q ? pend_keep_q : (kind_q == FK_CONV);
  assign rx_tag  = pend_q ? pend_tag_q : ptr_q;

  adc_seq_rx #(.RES_W(RES_BITS), .TAG_W(TAG_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .bit_i     (dout_i),
    .deliver_i (deliver),
    .keep_i    (keep),
    .tag_i     (rx_tag),
    .result_o  (result_o),
    .tag_o     (tag_o),
    .valid_o   (valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      kind_q      <= FK_CONV;
      ptr_q       <= '0;
      idx_q       <= '0;
      hi_q        <= 1'b0;
      cs_n_q      <= 1'b1;
      pend_q      <= 1'b0;
      pend_keep_q <= 1'b0;
      pend_tag_q  <= '0;
      div_q       <= '0;
      long_q      <= 1'b1;
      int_q       <= 1'b0;
      auto_q      <= 1'b0;
      last_q      <= '0;
      list_q      <= '0;
      mode_ok_q   <= 1'b0;
      mode_int_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          div_q      <= div_i;
          long_q     <= long_frame_i | int_clk_i;
          int_q      <= int_clk_i;
          auto_q     <= auto_pd_i;
          last_q     <= last_idx_i;
          list_q     <= list_i;
          kind_q     <= (!mode_ok_q || mode_int_q != int_clk_i) ? FK_SETUP : FK_CONV;
          mode_ok_q  <= 1'b1;
          mode_int_q <= int_clk_i;
          ptr_q      <= '0;
          idx_q      <= '0;
          hi_q       <= 1'b0;
          pend_q     <= 1'b0;
          cs_n_q     <= 1'b0;
          st_q       <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          if (!hi_q) begin
            hi_q <= 1'b1;
            if (idx_q == '0) pend_q <= 1'b0;
          end else begin
            hi_q <= 1'b0;
            if (idx_q == frame_last) begin
              idx_q <= '0;
              if (!long_q && kind_q != FK_FLUSH) begin
                pend_q      <= 1'b1;
                pend_keep_q <= (kind_q == FK_CONV);
                pend_tag_q  <= ptr_q;
              end
              unique case (kind_q)
                FK_SETUP: begin
                  kind_q <= FK_CONV;
                  ptr_q  <= '0;
                end
                FK_CONV: begin
                  if (ptr_q != last_q) ptr_q <= ptr_q + 1'b1;
                  else if (!long_q)    kind_q <= FK_FLUSH;
                  else begin
                    st_q   <= ST_IDLE;
                    cs_n_q <= 1'b1;
                  end
                end
                default: begin
                  st_q   <= ST_IDLE;
                  cs_n_q <= 1'b1;
                end
              endcase
            end else begin
              idx_q <= idx_q + 1'b1;
              if (int_q && kind_q != FK_FLUSH && idx_q == L_CTRL_LAST) st_q <= ST_WAIT_LO;
            end
          end
        end
        ST_WAIT_LO: if (!busy_s_q) st_q <= ST_WAIT_HI;
        ST_WAIT_HI: if (busy_s_q)  st_q <= ST_RUN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = cs_n_q;
  assign dclk_o = hi_q;

  assert_idle_pins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (cs_no && !dclk_o));
  assert_park_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_LO || st_q == ST_WAIT_HI) |-> (!dclk_o && !cs_no));
  assert_din_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |-> $stable(din_o));
  assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(list_q) && $stable(last_q) && $stable(div_q)));
  assert_ptr_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (ptr_q <= last_q));
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int DIV_W = 8;
  localparam int N_ENT = 8;
  localparam int TAG_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start = 1'b0;
  logic [DIV_W-1:0] div = 8'd1;
  logic             long_f = 1'b1, int_c = 1'b0, auto_pd = 1'b1;
  logic [TAG_W-1:0] last_idx = '0;
  logic [31:0]      list = 32'h5E93_C6A1;
  logic             cs_n, dclk, din;
  logic             dout = 1'b0, busy = 1'b1;
  logic [15:0]      res;
  logic [TAG_W-1:0] tag;
  logic             valid;

  adc_seq_top #(.DIV_W(DIV_W), .N_ENT(N_ENT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div),
    .long_frame_i(long_f), .int_clk_i(int_c), .auto_pd_i(auto_pd),
    .last_idx_i(last_idx), .list_i(list), .cs_no(cs_n), .dclk_o(dclk),
    .din_o(din), .dout_i(dout), .busy_i(busy), .result_o(res),
    .tag_o(tag), .valid_o(valid)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  logic [7:0]  sh, seq = 8'd0;
  logic [15:0] word;
  logic [16:0] osr = '0;
  logic        infr = 1'b0, dev_int = 1'b0;
  int          nb = 0, go_cnt = 0, seen_cnt = 0;
  logic [7:0]  ctrl_log [0:31];
  int          nctrl = 0, rises = 0, busy_rises = 0;

  always @(posedge dclk) if (!cs_n) begin
    rises++;
    if (!busy) busy_rises++;
    if (!infr) begin
      if (din) begin infr = 1'b1; sh = 8'h01; nb = 1; end
    end else begin
      sh = {sh[6:0], din};
      nb++;
      if (nb == 8) begin
        infr = 1'b0;
        if (nctrl < 32) ctrl_log[nctrl] = sh;
        nctrl++;
        if (sh[1:0] == 2'b10) dev_int = 1'b1;
        else if (sh[1:0] == 2'b11) dev_int = 1'b0;
        word = {sh, seq};
        seq  = seq + 8'd1;
        go_cnt++;
      end
    end
  end

  always @(negedge dclk) begin
    if (go_cnt != seen_cnt) begin
      seen_cnt = go_cnt;
      if (dev_int) begin
        dout = 1'b0;
        busy = 1'b0;
        repeat (25) @(posedge clk);
        busy = 1'b1;
        osr = {word, 1'b0};
      end else begin
        osr  = {1'b0, word};
        dout = osr[16];
        osr  = osr << 1;
      end
    end else begin
      dout = osr[16];
      osr  = osr << 1;
    end
  end

  // port monitors
  logic [15:0]      res_log [0:15];
  logic [TAG_W-1:0] tag_log [0:15];
  int nres = 0, vrun = 0, vmax = 0, hi_run = 0, hi_min = 0, hi_max = 0;
  int lead = 0, cs_falls = 0;
  bit got_hi = 0, cs_prev = 1;

  always @(negedge clk) begin
    if (valid) begin
      vrun++;
      if (vrun == 1 && nres < 16) begin res_log[nres] = res; tag_log[nres] = tag; end
      if (vrun == 1) nres++;
      if (vrun > vmax) vmax = vrun;
    end else vrun = 0;
    if (dclk) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    if (!cs_n && !got_hi) begin
      if (dclk) got_hi = 1; else lead++;
    end
    if (cs_prev && !cs_n) cs_falls++;
    cs_prev = cs_n;
  end

  function automatic logic [7:0] ectrl(input logic [3:0] e, input logic [1:0] pd);
    return {1'b1, e[3:1], 1'b0, e[0], pd};
  endfunction

  logic [31:0] list_s;
  int exp_base = 0;

  task automatic run_session(input bit disturb);
    int t;
    nres = 0; nctrl = 0; rises = 0; busy_rises = 0; vmax = 0;
    hi_min = 1000; hi_max = 0; lead = 0; got_hi = 0; cs_falls = 0;
    list_s = list;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    t = 0;
    while (cs_n && t < 100) begin @(negedge clk); t++; end
    if (disturb) begin
      while (nres == 0 && t < 20000) begin @(negedge clk); t++; end
      list = ~list; last_idx = 3'd7; long_f = 1'b0; div = 8'd0;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!cs_n && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(1'b0, "watchdog R12", 32'(t), 32'd0);
    repeat (6) @(negedge clk);
    chk(cs_n == 1'b1 && dclk == 1'b0, "R12 idle pins", {cs_n, dclk}, 32'h2);
    chk(cs_falls == 1, "R12 one select per run", 32'(cs_falls), 32'd1);
  endtask

  task automatic check_run(input bit dummy, input int n, input logic [1:0] pd_set,
                           input logic [1:0] pd_reg, input string req);
    int off;
    off = dummy ? 1 : 0;
    chk(nctrl == n + off, {req, " command count"}, 32'(nctrl), 32'(n + off));
    if (dummy)
      chk(ctrl_log[0] == ectrl(list_s[3:0], pd_set), "R7 setup command", ctrl_log[0],
          ectrl(list_s[3:0], pd_set));
    for (int k = 0; k < n; k++) begin
      logic [7:0] ec;
      ec = ectrl(list_s[4*k +: 4], pd_reg);
      chk(ctrl_log[k+off] == ec, "R3 R8 command byte", ctrl_log[k+off], ec);
      chk(tag_log[k] == 3'(k), "R9 tag", tag_log[k], k);
      chk(res_log[k] == {ec, 8'(exp_base + off + k)}, {req, " R9 result"}, res_log[k],
          {ec, 8'(exp_base + off + k)});
    end
    chk(nres == n, "R7 R11 result count", 32'(nres), 32'(n));
    chk(vmax == 1, "R11 strobe width", 32'(vmax), 32'd1);
    exp_base += n + off;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && dclk == 1'b0 && din == 1'b0 && valid == 1'b0, "R1 reset outputs",
        {cs_n, dclk, din, valid}, 32'h8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ext_long_first;
    div = 8'd1; long_f = 1'b1; int_c = 1'b0; auto_pd = 1'b1; last_idx = 3'd2;
    run_session(1'b0);
    check_run(1'b1, 3, 2'b11, 2'b00, "R4 R7");
    chk(rises == 4*32, "R4 clocks per run", 32'(rises), 32'd128);
    chk(hi_min == 2 && hi_max == 2, "R2 high phase", 32'(hi_max), 32'd2);
    chk(lead >= 2, "R2 lead time", 32'(lead), 32'd2);
  endtask

  task automatic t_short_frames;
    div = 8'd0; long_f = 1'b0; int_c = 1'b0; auto_pd = 1'b0; last_idx = 3'd7;
    run_session(1'b0);
    check_run(1'b0, 8, 2'b11, 2'b11, "R5");
    chk(rises == 8*24 + 8, "R5 clocks incl trailing transfer", 32'(rises), 32'd200);
    chk(hi_max == 1, "R2 high phase div0", 32'(hi_max), 32'd1);
  endtask

  task automatic t_internal;
    div = 8'd2; long_f = 1'b0; int_c = 1'b1; auto_pd = 1'b1; last_idx = 3'd1;
    run_session(1'b0);
    check_run(1'b1, 2, 2'b10, 2'b00, "R6 R7");
    chk(rises == 3*32, "R6 clocks per run", 32'(rises), 32'd96);
    chk(busy_rises == 0, "R6 clock parked while busy", 32'(busy_rises), 32'd0);
  endtask

  task automatic t_mode_back;
    div = 8'd3; long_f = 1'b1; int_c = 1'b0; auto_pd = 1'b0; last_idx = 3'd0;
    run_session(1'b0);
    check_run(1'b1, 1, 2'b11, 2'b11, "R7 R8 single entry");
    chk(rises == 2*32, "R4 clocks single entry", 32'(rises), 32'd64);
    chk(hi_min == 4 && hi_max == 4, "R2 high phase div3", 32'(hi_max), 32'd4);
  endtask

  task automatic t_ignore_start;
    div = 8'd1; long_f = 1'b1; int_c = 1'b0; auto_pd = 1'b1; last_idx = 3'd1;
    run_session(1'b1);
    check_run(1'b0, 2, 2'b11, 2'b00, "R10");
    chk(rises == 2*32, "R10 framing unchanged", 32'(rises), 32'd64);
    chk(hi_max == 2, "R10 divider unchanged", 32'(hi_max), 32'd2);
  endtask

  initial begin
    t_reset();
    t_ext_long_first();
    t_short_frames();
    t_internal();
    t_mode_back();
    t_ignore_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule